// File: doc/BRIEF.md
# Debug Command and Status Shifter

This unit is a data-register path placed behind a boundary-scan TAP controller on a debug port. The TAP drives its Capture-DR, Shift-DR and Update-DR state strobes, TDI and the test clock; the unit returns TDO and an output-enable that stands for the tri-state control. The scan length is not fixed. By default every scan is an 8-bit command scan. While the debugger shifts an opcode in, the unit shifts the core's status byte out, so one scan both issues a command and polls the core.

At Update-DR the opcode is held and decoded. An opcode that names one of the 16-bit debug registers makes the following scan 16 bits long. That scan either reads the named register, which is loaded at Capture-DR, or writes it, with the shifted word committed at Update-DR. Selection then falls back to the command shifter. Any other opcode leaves the command shifter selected. While the core reports its stop state, no status is returned and no access is serviced.

Top module: `dbg_cmd_shifter`

## Requirements
- R1: A low `rst_n` at a rising TCK edge (Test-Logic-Reset) clears the held opcode to 0x00 and selects the 8-bit command scan. This applies even when a 16-bit scan was pending. It also clears all four debug registers to 0x0000.
- R2: In a command scan, Capture-DR loads the live `core_status` byte, and Shift-DR sends it out on TDO least significant bit first over 8 bits. The value 0x00 reports a running core and 0x1A reports a core halted in debug mode by a hardware breakpoint.
- R3: TDO and `tdo_oe` change on the falling TCK edge. `tdo_oe` is high exactly during Shift-DR and low otherwise, and TDO is 0 while `tdo_oe` is low.
- R4: After an update with opcode 0x00, the next scan is again an 8-bit command scan that returns status.
- R5: A write opcode has bit 7 = 0, bits 6:3 = 0 and bits 2:0 = n with n in 1..4, naming register n-1. It makes the next scan 16 bits long, and that scan shifts out 0x0000. At its Update-DR the 16-bit word shifted in (LSB first) is written to the register. The scan after it is an 8-bit command scan.
- R6: A read opcode has bit 7 = 1 and the same register field. It makes the next scan 16 bits long, with register n-1 loaded at Capture-DR and shifted out LSB first. The scan after it is an 8-bit command scan.
- R7: An opcode with bits 2:0 equal to 0, 5, 6 or 7, or with any of bits 6:3 set, behaves like 0x00, whatever bit 7 holds.
- R8: While `core_stopped` is high, a command scan shifts out 0x00 and an opcode update selects no 16-bit scan. A 16-bit scan shifts out 0x0000 and its Update-DR writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset (Test-Logic-Reset) |
| capture_dr | input | 1 | TAP is in Capture-DR |
| shift_dr | input | 1 | TAP is in Shift-DR |
| update_dr | input | 1 | TAP is in Update-DR |
| tdi | input | 1 | Serial data in |
| core_status | input | 8 | Live core status byte |
| core_stopped | input | 1 | Core is in its stop state |
| tdo | output | 1 | Serial data out, falling-edge timed |
| tdo_oe | output | 1 | TDO drive enable (low = tri-state) |

## Verification
The bench drives chained sequences in which each scan's length depends on the opcode before it. A design that picks the wrong length misaligns every scan that follows, so the shifted-out words no longer match. It probes undefined register codes and set middle bits with bit 7 high. A decoder that looks only at the low bits would open a 16-bit scan there and return register data where status is expected. It issues a write opcode and a write scan while the core is stopped, then reads the register back. A design that ignores the stop input would show a changed register or a non-zero status. A reset placed between a read opcode and its 16-bit scan checks that the pending selection is dropped and the registers come back as zero.

// File: rtl/dbg_pkg.sv
// Shared sizes for the debug command/status shifter.
// Assumes a single TCK domain; all widths derive from these values.
package dbg_pkg;
    parameter int CMD_W    = 8;
    parameter int REG_W    = 16;
    parameter int NUM_REGS = 4;
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int CODE_W  = $clog2(NUM_REGS + 1);
endpackage

// File: rtl/dbg_op_decode.sv
// Opcode decoder: bit CMD_W-1 is read(1)/write(0), the low CODE_W bits
// name register code-1 (codes 1..NUM_REGS), the middle bits must be zero.
// Assumes CMD_W-1 > CODE_W. Purely combinational.
module dbg_op_decode #(
    parameter int CMD_W    = 8,
    parameter int NUM_REGS = 4,
    parameter int IDX_W    = 2,
    parameter int CODE_W   = 3
) (
    input  logic [CMD_W-1:0] op,
    output logic             acc_valid,
    output logic             acc_rd,
    output logic [IDX_W-1:0] acc_idx
);
    logic [CODE_W-1:0]         code;
    logic [CMD_W-2-CODE_W:0]   mid;

    // split the opcode and judge whether it names a register
    always_comb begin
        code      = op[CODE_W-1:0];
        mid       = op[CMD_W-2:CODE_W];
        acc_rd    = op[CMD_W-1];
        acc_valid = (mid == '0) && (code != '0) && (int'(code) <= NUM_REGS);
        acc_idx   = IDX_W'(code - CODE_W'(1));
    end
endmodule

// File: rtl/dbg_reg_bank.sv
// Bank of NUM_REGS debug registers, written only on a we pulse,
// read combinationally by index. Synchronous active-low reset to zero.
module dbg_reg_bank #(
    parameter int REG_W    = 16,
    parameter int NUM_REGS = 4,
    parameter int IDX_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [REG_W-1:0] wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [REG_W-1:0] rdata
);
    logic [NUM_REGS-1:0][REG_W-1:0] mem;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // one register: clear on reset, load when addressed by a write
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (we && (int'(widx) == g))
                mem[g] <= wdata;
        end
    end

    // read mux; out-of-range index reads zero
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (int'(ridx) == i) rdata = mem[i];
    end

    // R5
    write_only_on_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mem));
endmodule

// File: rtl/dbg_tdo_stage.sv
// Falling-edge output stage: presents the shifter's LSB on TDO and raises
// the drive enable only while Shift-DR is active, as boundary scan requires.
module dbg_tdo_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic bit_in,
    output logic tdo,
    output logic tdo_oe
);
    // retime serial output and enable onto the falling edge
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= shift_en ? bit_in : 1'b0;
            tdo_oe <= shift_en;
        end
    end
endmodule

// File: rtl/dbg_cmd_shifter.sv
// Debug data-register unit behind a TAP controller. Alternates an 8-bit
// command scan (status out, opcode in) with an optional 16-bit register
// scan picked by the held opcode. Assumes the TAP strobes are one-hot,
// change just after the rising TCK edge, and rst_n mirrors Test-Logic-Reset.
module dbg_cmd_shifter
    import dbg_pkg::*;
(
    input  logic             tck,
    input  logic             rst_n,
    input  logic             capture_dr,
    input  logic             shift_dr,
    input  logic             update_dr,
    input  logic             tdi,
    input  logic [CMD_W-1:0] core_status,
    input  logic             core_stopped,
    output logic             tdo,
    output logic             tdo_oe
);
    logic [REG_W-1:0] shreg;
    logic [CMD_W-1:0] cmd_q;
    logic             long_pend;
    logic             acc_valid, acc_rd;
    logic [IDX_W-1:0] acc_idx;
    logic             sel_long;
    logic             bank_we;
    logic [REG_W-1:0] bank_rdata;

    dbg_op_decode #(.CMD_W(CMD_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .CODE_W(CODE_W)) u_dec (
        .op(cmd_q), .acc_valid(acc_valid), .acc_rd(acc_rd), .acc_idx(acc_idx)
    );

    dbg_reg_bank #(.REG_W(REG_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
        .clk(tck), .rst_n(rst_n), .we(bank_we), .widx(acc_idx),
        .wdata(shreg), .ridx(acc_idx), .rdata(bank_rdata)
    );

    dbg_tdo_stage u_out (
        .clk(tck), .rst_n(rst_n), .shift_en(shift_dr), .bit_in(shreg[0]),
        .tdo(tdo), .tdo_oe(tdo_oe)
    );

    // 16-bit path is live only when owed and the held opcode names a register
    always_comb begin
        sel_long = long_pend && acc_valid;
        bank_we  = update_dr && sel_long && !acc_rd && !core_stopped;
    end

    // capture and shift of the variable-length data register
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (capture_dr) begin
            if (sel_long)
                shreg <= (acc_rd && !core_stopped) ? bank_rdata : '0;
            else
                shreg <= {{(REG_W-CMD_W){1'b0}}, (core_stopped ? {CMD_W{1'b0}} : core_status)};
        end else if (shift_dr) begin
            if (sel_long)
                shreg <= {tdi, shreg[REG_W-1:1]};
            else
                shreg[CMD_W-1:0] <= {tdi, shreg[CMD_W-1:1]};
        end
    end

    // opcode hold and scan-length selection at Update-DR
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            long_pend <= 1'b0;
        end else if (update_dr) begin
            if (sel_long) begin
                long_pend <= 1'b0;
            end else begin
                cmd_q     <= shreg[CMD_W-1:0];
                long_pend <= !core_stopped;
            end
        end
    end

    // R3
    oe_tracks_shift_chk: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_oe == shift_dr);

    // R3
    tdo_quiet_chk: assert property (@(posedge tck) disable iff (!rst_n)
        !tdo_oe |-> !tdo);

    // R2
    capture_loads_status_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (capture_dr && !sel_long && !core_stopped) |=> shreg[CMD_W-1:0] == $past(core_status));

    // R4
    zero_op_stays_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (update_dr && !sel_long && shreg[CMD_W-1:0] == '0) |=> !sel_long);

    // R5
    long_scan_ends_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (update_dr && sel_long) |=> !sel_long);

    // R7
    undef_op_idle_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (update_dr && !sel_long && shreg[CMD_W-2:CODE_W] != '0) |=> !sel_long);

    // R8
    stopped_no_select_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (update_dr && !sel_long && core_stopped) |=> !sel_long);
endmodule

// File: tb/sim_dbg_cmd_shifter.sv
module sim_dbg_cmd_shifter;
    logic tck = 1'b0;
    logic rst_n = 1'b0;
    logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
    logic [7:0] core_status = 8'h00;
    logic core_stopped = 1'b0;
    logic tdo, tdo_oe;
    int   n_chk = 0, n_bad = 0;
    bit   done = 1'b0;

    always #2.5 tck = ~tck;

    dbg_cmd_shifter u0 (
        .tck(tck), .rst_n(rst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .update_dr(update_dr), .tdi(tdi), .core_status(core_status),
        .core_stopped(core_stopped), .tdo(tdo), .tdo_oe(tdo_oe)
    );

    // {long, stopped, status, data in, expected out}
    localparam int NV = 21;
    localparam logic [41:0] TBL [0:NV-1] = '{
        {1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000}, // R2 running status, R4 zero op
        {1'b0, 1'b0, 8'h1A, 16'h0001, 16'h001A}, // R4 still 8 bits, R2 halted; write reg0
        {1'b1, 1'b0, 8'h1A, 16'hBEEF, 16'h0000}, // R5 write scan
        {1'b0, 1'b0, 8'h1A, 16'h0081, 16'h001A}, // R5 back to command; read reg0
        {1'b1, 1'b0, 8'h00, 16'h1234, 16'hBEEF}, // R6
        {1'b0, 1'b0, 8'h55, 16'h0004, 16'h0055}, // write reg3
        {1'b1, 1'b0, 8'h00, 16'hA5C3, 16'h0000}, // R5
        {1'b0, 1'b0, 8'h3C, 16'h0084, 16'h003C}, // R6 read reg3
        {1'b1, 1'b0, 8'h00, 16'h0000, 16'hA5C3}, // R6
        {1'b0, 1'b0, 8'h1A, 16'h0085, 16'h001A}, // R7 code 5
        {1'b0, 1'b0, 8'h77, 16'h0089, 16'h0077}, // R7 stayed short; mid bit set
        {1'b0, 1'b0, 8'h66, 16'h0082, 16'h0066}, // R7 stayed short; read reg1
        {1'b1, 1'b0, 8'h00, 16'hFFFF, 16'h0000}, // R1 reg1 reset value
        {1'b0, 1'b1, 8'h1A, 16'h0002, 16'h0000}, // R8 stopped: no status
        {1'b0, 1'b0, 8'h21, 16'h0081, 16'h0021}, // R8 previous opcode not taken
        {1'b1, 1'b0, 8'h00, 16'h0000, 16'hBEEF}, // R8 reg0 kept
        {1'b0, 1'b0, 8'h10, 16'h0001, 16'h0010}, // write reg0
        {1'b1, 1'b1, 8'h00, 16'h1111, 16'h0000}, // R8 write scan while stopped
        {1'b0, 1'b0, 8'h20, 16'h0081, 16'h0020}, // read reg0
        {1'b1, 1'b0, 8'h00, 16'h0000, 16'hBEEF}, // R8 no commit
        {1'b0, 1'b0, 8'h5A, 16'h0000, 16'h005A}  // R4
    };

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cyc();
        @(posedge tck); #1;
    endtask

    // one full capture/shift/update pass; checks oe during and after shift
    task automatic scan(input int len, input logic [15:0] din, output logic [15:0] dout);
        logic oe_ok;
        dout = '0;
        oe_ok = 1'b1;
        capture_dr = 1'b1; cyc(); capture_dr = 1'b0;
        shift_dr = 1'b1;
        for (int i = 0; i < len; i++) begin
            tdi = din[i];
            @(negedge tck); #1;
            dout[i] = tdo;
            if (tdo_oe !== 1'b1) oe_ok = 1'b0;
            cyc();
        end
        shift_dr = 1'b0;
        update_dr = 1'b1; cyc(); update_dr = 1'b0;
        @(negedge tck); #1;
        chk("R3 oe high in shift", {15'b0, oe_ok}, 16'h0001);
        chk("R3 oe low / tdo 0 at idle", {14'b0, tdo_oe, tdo}, 16'h0000);
        cyc();
    endtask

    initial begin
        logic [15:0] got;
        repeat (3) cyc();
        @(negedge tck); #1;
        chk("R1 reset oe", {15'b0, tdo_oe}, 16'h0000);
        rst_n = 1'b1;
        cyc();
        for (int v = 0; v < NV; v++) begin
            core_stopped = TBL[v][40];
            core_status  = TBL[v][39:32];
            scan(TBL[v][41] ? 16 : 8, TBL[v][31:16], got);
            chk($sformatf("R2/R4-R8 vector %0d", v), got, TBL[v][15:0]);
        end
        core_stopped = 1'b0;
        // R1: reset while a 16-bit read is pending
        core_status = 8'h42;
        scan(8, 16'h0081, got);
        chk("R1 setup status", got, 16'h0042);
        rst_n = 1'b0; cyc(); cyc(); rst_n = 1'b1; cyc();
        core_status = 8'h1A;
        scan(8, 16'h0081, got);
        chk("R1 command scan after reset", got, 16'h001A);
        scan(16, 16'h0000, got);
        chk("R1 reg0 cleared", got, 16'h0000);
        scan(8, 16'h0000, got);
        chk("R1 back to command", got, 16'h001A);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule